// File: doc/BRIEF.md
# Shared Command-Bus Grant Arbiter

This block sits between the per-bank selection logic of a DRAM controller and the single address/command bus of the memory devices. Every cycle it can receive one precharge candidate and one activate candidate from each bank, plus the one column access that the shared column arbiter has already picked. Only one of these can use the bus in a cycle. The block picks a winner, acknowledges that requester in the same cycle, and presents the granted command, with its bank and its row or column address, on registered outputs in the next cycle.

A two-bit policy input sets the order of preference. The oldest mode follows reference age. The three class-first modes favour precharges, activations or column accesses. Favouring column accesses shortens the latency of hits to rows that are already open. Favouring precharges or activations keeps more banks busy at once. A precharge aimed at the bank that the pending column access targets is held back, so the two can never both be issued. If that column access carries an automatic precharge and wins, the held-back precharge is acknowledged together with it and is retired.

The registered command output works as a small state machine. Its states are NOP, PRE, ACT and COL. The state taken at each edge comes from the decision made in the cycle before: NOP when no candidate is present, otherwise the class of the winner.

Top module: `cmd_bus_arbiter`

## Requirements
- R1: While reset is asserted, `cmd_kind` is NOP (0) and `cmd_bank`, `cmd_addr` and `cmd_auto_pre` are 0.
- R2: When no request is present, no acknowledge is raised and `cmd_kind` is NOP at the next clock edge.
- R3: In a cycle with at least one eligible request, exactly one requester is acknowledged. The only extra acknowledge allowed is the retired precharge of R10. No acknowledge is ever raised without its request.
- R4: With `policy` = 1 (precharge first), class preference is PRE over ACT over COL.
- R5: With `policy` = 2 (activate first), class preference is ACT over PRE over COL.
- R6: With `policy` = 3 (column first), class preference is COL over PRE over ACT.
- R7: With `policy` = 0 (oldest first), the candidate with the largest age tag wins. Equal ages are resolved as PRE over ACT over COL, then by lowest bank.
- R8: Within one class, the lowest bank index wins.
- R9: A precharge request to the bank named by `col_bank` while `col_req` is high is never granted on its own.
- R10: When a column access with `col_auto_pre` = 1 is granted and a precharge request to the same bank is present, that precharge is acknowledged in the same cycle. The issued command carries `cmd_auto_pre` = 1.
- R11: One edge after an acknowledge, `cmd_kind` gives the winner's class (PRE=1, ACT=2, COL=3) and `cmd_bank` gives its bank. `cmd_addr` is 0 for PRE, the row for ACT, and the zero-extended column for COL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy | input | 2 | 0 oldest, 1 precharge first, 2 activate first, 3 column first |
| pre_req | input | NB | Precharge candidate per bank |
| pre_age | input | NB*AGE_W | Age tag of each precharge candidate |
| act_req | input | NB | Activate candidate per bank |
| act_row | input | NB*ROW_W | Row to open for each activate candidate |
| act_age | input | NB*AGE_W | Age tag of each activate candidate |
| col_req | input | 1 | Column access candidate |
| col_bank | input | BANK_W | Bank of the column access |
| col_addr | input | COL_W | Column address |
| col_auto_pre | input | 1 | Column access closes its row afterwards |
| col_age | input | AGE_W | Age tag of the column access |
| pre_ack | output | NB | Precharge candidate accepted this cycle |
| act_ack | output | NB | Activate candidate accepted this cycle |
| col_ack | output | 1 | Column candidate accepted this cycle |
| cmd_kind | output | 2 | Issued command: 0 NOP, 1 PRE, 2 ACT, 3 COL |
| cmd_bank | output | BANK_W | Bank of the issued command |
| cmd_addr | output | max(ROW_W,COL_W) | Row or column of the issued command |
| cmd_auto_pre | output | 1 | Issued column access closes its row |

## Verification
The assertions check the following on every cycle: idle behaviour, that at most one requester wins, that no acknowledge appears without its request, that a winner always exists when a request is eligible, the same-bank conflict rule with its retired precharge, the column-first preference, and that the registered command matches the acknowledge that produced it. Some results depend on the full request pattern and cannot be shown by a single property: the complete preference ordering of each policy, age comparison with its tie resolution, the lowest-bank choice, and the exact address presented. These are shown only by the bench's sweep, which compares every case against an arithmetic model.

// File: rtl/cmd_arb_pkg.sv
package cmd_arb_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_PRE = 2'd1,
        CMD_ACT = 2'd2,
        CMD_COL = 2'd3
    } cmd_kind_e;

    typedef enum logic [1:0] {
        POL_OLDEST = 2'd0,
        POL_PRE    = 2'd1,
        POL_ROW    = 2'd2,
        POL_COL    = 2'd3
    } policy_e;

endpackage

// File: rtl/cmd_arb_keygen.sv
// Builds one comparable priority key per candidate: {valid, age-or-0, class rank, ~bank}.
module cmd_arb_keygen
    import cmd_arb_pkg::*;
#(
    parameter int AGE_W  = 4,
    parameter int BANK_W = 2,
    localparam int KEY_W = 1 + AGE_W + 2 + BANK_W
) (
    input  logic              valid,
    input  cmd_kind_e         cls,
    input  policy_e           policy,
    input  logic [AGE_W-1:0]  age,
    input  logic [BANK_W-1:0] bank,
    output logic [KEY_W-1:0]  key
);
    logic [1:0]       rank;
    logic [AGE_W-1:0] age_term;

    always_comb begin
        rank = 2'd0;
        unique case (policy)
            POL_OLDEST, POL_PRE: begin
                unique case (cls)
                    CMD_PRE: rank = 2'd3;
                    CMD_ACT: rank = 2'd2;
                    CMD_COL: rank = 2'd1;
                    default: rank = 2'd0;
                endcase
            end
            POL_ROW: begin
                unique case (cls)
                    CMD_ACT: rank = 2'd3;
                    CMD_PRE: rank = 2'd2;
                    CMD_COL: rank = 2'd1;
                    default: rank = 2'd0;
                endcase
            end
            POL_COL: begin
                unique case (cls)
                    CMD_COL: rank = 2'd3;
                    CMD_PRE: rank = 2'd2;
                    CMD_ACT: rank = 2'd1;
                    default: rank = 2'd0;
                endcase
            end
            default: rank = 2'd0;
        endcase
        age_term = (policy == POL_OLDEST) ? age : '0;
        key      = valid ? {1'b1, age_term, rank, ~bank} : '0;
    end
endmodule

// File: rtl/cmd_arb_pick.sv
// Selects the candidate holding the largest key.
module cmd_arb_pick #(
    parameter int N     = 9,
    parameter int KEY_W = 9,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N*KEY_W-1:0] keys,
    output logic [IDX_W-1:0]   win_idx,
    output logic               found
);
    logic [KEY_W-1:0] best;

    always_comb begin
        best    = '0;
        win_idx = '0;
        found   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (keys[i*KEY_W +: KEY_W] > best) begin
                best    = keys[i*KEY_W +: KEY_W];
                win_idx = IDX_W'(i);
                found   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cmd_bus_arbiter.sv
module cmd_bus_arbiter
    import cmd_arb_pkg::*;
#(
    parameter int NB     = 4,
    parameter int ROW_W  = 12,
    parameter int COL_W  = 9,
    parameter int AGE_W  = 4,
    localparam int BANK_W = (NB > 1) ? $clog2(NB) : 1,
    localparam int AD_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            policy,
    input  logic [NB-1:0]         pre_req,
    input  logic [NB*AGE_W-1:0]   pre_age,
    input  logic [NB-1:0]         act_req,
    input  logic [NB*ROW_W-1:0]   act_row,
    input  logic [NB*AGE_W-1:0]   act_age,
    input  logic                  col_req,
    input  logic [BANK_W-1:0]     col_bank,
    input  logic [COL_W-1:0]      col_addr,
    input  logic                  col_auto_pre,
    input  logic [AGE_W-1:0]      col_age,
    output logic [NB-1:0]         pre_ack,
    output logic [NB-1:0]         act_ack,
    output logic                  col_ack,
    output logic [1:0]            cmd_kind,
    output logic [BANK_W-1:0]     cmd_bank,
    output logic [AD_W-1:0]       cmd_addr,
    output logic                  cmd_auto_pre
);
    localparam int NC    = 2 * NB + 1;
    localparam int IDX_W = $clog2(NC);
    localparam int KEY_W = 1 + AGE_W + 2 + BANK_W;

    policy_e           pol;
    logic [NB-1:0]     pre_ok;
    logic [NC*KEY_W-1:0] keys;
    logic [IDX_W-1:0]  win_idx;
    logic              found;

    cmd_kind_e         state_q, state_d;
    logic [BANK_W-1:0] bank_d;
    logic [AD_W-1:0]   addr_d;
    logic              ap_d;

    assign pol = policy_e'(policy);

    // A precharge to the bank the pending column access needs is held back.
    always_comb begin
        for (int b = 0; b < NB; b++) begin
            pre_ok[b] = pre_req[b] && !(col_req && (int'(col_bank) == b));
        end
    end

    for (genvar i = 0; i < NC; i++) begin : g_cand
        if (i < NB) begin : g_pre
            cmd_arb_keygen #(.AGE_W(AGE_W), .BANK_W(BANK_W)) kg_i (
                .valid (pre_ok[i]),
                .cls   (CMD_PRE),
                .policy(pol),
                .age   (pre_age[i*AGE_W +: AGE_W]),
                .bank  (BANK_W'(i)),
                .key   (keys[i*KEY_W +: KEY_W])
            );
        end else if (i < 2 * NB) begin : g_act
            cmd_arb_keygen #(.AGE_W(AGE_W), .BANK_W(BANK_W)) kg_i (
                .valid (act_req[i-NB]),
                .cls   (CMD_ACT),
                .policy(pol),
                .age   (act_age[(i-NB)*AGE_W +: AGE_W]),
                .bank  (BANK_W'(i - NB)),
                .key   (keys[i*KEY_W +: KEY_W])
            );
        end else begin : g_col
            cmd_arb_keygen #(.AGE_W(AGE_W), .BANK_W(BANK_W)) kg_i (
                .valid (col_req),
                .cls   (CMD_COL),
                .policy(pol),
                .age   (col_age),
                .bank  (col_bank),
                .key   (keys[i*KEY_W +: KEY_W])
            );
        end
    end

    cmd_arb_pick #(.N(NC), .KEY_W(KEY_W)) pick_i (
        .keys   (keys),
        .win_idx(win_idx),
        .found  (found)
    );

    // Next-state and acknowledge decode.
    always_comb begin
        state_d = CMD_NOP;
        bank_d  = '0;
        addr_d  = '0;
        ap_d    = 1'b0;
        pre_ack = '0;
        act_ack = '0;
        col_ack = 1'b0;
        if (found) begin
            if (int'(win_idx) < NB)          state_d = CMD_PRE;
            else if (int'(win_idx) < 2 * NB) state_d = CMD_ACT;
            else                             state_d = CMD_COL;
        end
        unique case (state_d)
            CMD_NOP: ;
            CMD_PRE: begin
                bank_d           = BANK_W'(win_idx);
                pre_ack[bank_d]  = 1'b1;
            end
            CMD_ACT: begin
                bank_d           = BANK_W'(int'(win_idx) - NB);
                act_ack[bank_d]  = 1'b1;
                addr_d           = AD_W'(act_row[bank_d*ROW_W +: ROW_W]);
            end
            CMD_COL: begin
                bank_d  = col_bank;
                addr_d  = AD_W'(col_addr);
                ap_d    = col_auto_pre;
                col_ack = 1'b1;
                if (col_auto_pre && pre_req[col_bank]) pre_ack[col_bank] = 1'b1;
            end
            default: ;
        endcase
    end

    // State register: the command issued on the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= CMD_NOP;
            cmd_bank     <= '0;
            cmd_addr     <= '0;
            cmd_auto_pre <= 1'b0;
        end else begin
            state_q      <= state_d;
            cmd_bank     <= bank_d;
            cmd_addr     <= addr_d;
            cmd_auto_pre <= ap_d;
        end
    end

    assign cmd_kind = state_q;
endmodule

// File: rtl/cmd_arb_chk.sv
module cmd_arb_chk #(
    parameter int NB     = 4,
    parameter int ROW_W  = 12,
    parameter int COL_W  = 9,
    parameter int AGE_W  = 4,
    localparam int BANK_W = (NB > 1) ? $clog2(NB) : 1,
    localparam int AD_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          policy,
    input logic [NB-1:0]       pre_req,
    input logic [NB-1:0]       act_req,
    input logic                col_req,
    input logic [BANK_W-1:0]   col_bank,
    input logic                col_auto_pre,
    input logic [NB-1:0]       pre_ack,
    input logic [NB-1:0]       act_ack,
    input logic                col_ack,
    input logic [1:0]          cmd_kind,
    input logic [BANK_W-1:0]   cmd_bank
);
    AST_IDLE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_req == '0 && act_req == '0 && !col_req) |=> cmd_kind == 2'd0); // R2

    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        !(col_ack && col_auto_pre) |-> $countones({pre_ack, act_ack, col_ack}) <= 1); // R3

    AST_ACK_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((pre_ack & ~pre_req) == '0) && ((act_ack & ~act_req) == '0) && (!col_ack || col_req)); // R3

    AST_SOME_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_req != '0 || act_req != '0 || col_req) |-> (pre_ack != '0 || act_ack != '0 || col_ack)); // R3

    AST_SAME_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (col_req && pre_ack[col_bank]) |-> (col_ack && col_auto_pre)); // R9

    AST_COL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (policy == 2'd3 && col_req) |-> col_ack); // R6

    AST_COL_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
        col_ack |=> (cmd_kind == 2'd3 && cmd_bank == $past(col_bank))); // R11

    AST_ACT_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
        (act_ack != '0) |=> cmd_kind == 2'd2); // R11
endmodule

bind cmd_bus_arbiter cmd_arb_chk #(.NB(NB), .ROW_W(ROW_W), .COL_W(COL_W), .AGE_W(AGE_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .policy(policy), .pre_req(pre_req), .act_req(act_req),
    .col_req(col_req), .col_bank(col_bank), .col_auto_pre(col_auto_pre),
    .pre_ack(pre_ack), .act_ack(act_ack), .col_ack(col_ack),
    .cmd_kind(cmd_kind), .cmd_bank(cmd_bank)
);

// File: tb/cmd_bus_arbiter_tb_top.sv
module cmd_bus_arbiter_tb_top;
    localparam int NB = 2, ROW_W = 4, COL_W = 3, AGE_W = 2, BW = 1, AD_W = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                rst_n;
    logic [1:0]          policy;
    logic [NB-1:0]       pre_req, act_req, pre_ack, act_ack;
    logic [NB*AGE_W-1:0] pre_age, act_age;
    logic [NB*ROW_W-1:0] act_row;
    logic                col_req, col_auto_pre, col_ack, cmd_auto_pre;
    logic [BW-1:0]       col_bank, cmd_bank;
    logic [COL_W-1:0]    col_addr;
    logic [AGE_W-1:0]    col_age;
    logic [1:0]          cmd_kind;
    logic [AD_W-1:0]     cmd_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    cmd_bus_arbiter #(.NB(NB), .ROW_W(ROW_W), .COL_W(COL_W), .AGE_W(AGE_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .policy(policy),
        .pre_req(pre_req), .pre_age(pre_age), .act_req(act_req), .act_row(act_row),
        .act_age(act_age), .col_req(col_req), .col_bank(col_bank), .col_addr(col_addr),
        .col_auto_pre(col_auto_pre), .col_age(col_age),
        .pre_ack(pre_ack), .act_ack(act_ack), .col_ack(col_ack),
        .cmd_kind(cmd_kind), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
        .cmd_auto_pre(cmd_auto_pre)
    );

    task automatic check(bit ok, string tag, int actual, int expected);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    // Arithmetic reference: returns the winning class (0 none,1 PRE,2 ACT,3 COL) and bank.
    task automatic model(output int kind, output int bank);
        logic [NB-1:0] pok;
        int best;
        int order [3];
        kind = 0;
        bank = 0;
        for (int b = 0; b < NB; b++) pok[b] = pre_req[b] && !(col_req && int'(col_bank) == b);
        if (policy == 2'd0) begin
            best = -1;
            for (int b = 0; b < NB; b++)
                if (pok[b] && int'(pre_age[b*AGE_W +: AGE_W]) > best) begin
                    best = int'(pre_age[b*AGE_W +: AGE_W]); kind = 1; bank = b;
                end
            for (int b = 0; b < NB; b++)
                if (act_req[b] && int'(act_age[b*AGE_W +: AGE_W]) > best) begin
                    best = int'(act_age[b*AGE_W +: AGE_W]); kind = 2; bank = b;
                end
            if (col_req && int'(col_age) > best) begin
                kind = 3; bank = int'(col_bank);
            end
        end else begin
            if (policy == 2'd1)      order = '{1, 2, 3};
            else if (policy == 2'd2) order = '{2, 1, 3};
            else                     order = '{3, 1, 2};
            for (int k = 0; k < 3; k++) begin
                if (kind == 0) begin
                    if (order[k] == 1) begin
                        for (int b = NB - 1; b >= 0; b--) if (pok[b]) begin kind = 1; bank = b; end
                    end else if (order[k] == 2) begin
                        for (int b = NB - 1; b >= 0; b--) if (act_req[b]) begin kind = 2; bank = b; end
                    end else if (col_req) begin
                        kind = 3; bank = int'(col_bank);
                    end
                end
            end
        end
    endtask

    task automatic run_vector(string pol_tag);
        int k, bk, e_addr, e_ap;
        logic [NB-1:0] e_pre, e_act;
        logic e_col;
        string tag;
        model(k, bk);
        e_pre = '0; e_act = '0; e_col = 1'b0; e_addr = 0; e_ap = 0;
        if (k == 1) e_pre[bk] = 1'b1;
        if (k == 2) begin e_act[bk] = 1'b1; e_addr = int'(act_row[bk*ROW_W +: ROW_W]); end
        if (k == 3) begin
            e_col = 1'b1; e_addr = int'(col_addr); e_ap = int'(col_auto_pre);
            if (col_auto_pre && pre_req[col_bank]) e_pre[col_bank] = 1'b1;
        end
        if (k == 0) tag = "R2";
        else if (k == 3 && col_auto_pre && pre_req[col_bank]) tag = "R10";
        else if (col_req && pre_req[col_bank]) tag = "R9";
        else tag = pol_tag;
        #1;
        check({pre_ack, act_ack, col_ack} == {e_pre, e_act, e_col}, tag,
              int'({pre_ack, act_ack, col_ack}), int'({e_pre, e_act, e_col}));
        check(k == 0 || (col_ack && col_auto_pre) ||
              $countones({pre_ack, act_ack, col_ack}) == 1, "R3",
              $countones({pre_ack, act_ack, col_ack}), 1);
        @(posedge clk);
        #1;
        check(int'(cmd_kind) == k, (k == 0) ? "R2" : "R11", int'(cmd_kind), k);
        if (k != 0) begin
            check(int'(cmd_bank) == bk && int'(cmd_addr) == e_addr && int'(cmd_auto_pre) == e_ap,
                  (e_ap != 0) ? "R10" : "R11",
                  int'({cmd_bank, cmd_addr, cmd_auto_pre}), (bk << 5) | (e_addr << 1) | e_ap);
        end
        @(negedge clk);
    endtask

    task automatic clear_inputs();
        policy = 2'd0; pre_req = '0; act_req = '0; col_req = 1'b0; col_bank = '0;
        col_addr = '0; col_auto_pre = 1'b0; col_age = '0;
        pre_age = '0; act_age = '0; act_row = '0;
    endtask

    initial begin
        #(200_000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        string ptag [4];
        ptag = '{"R7", "R4", "R5", "R6"};
        clear_inputs();
        rst_n = 1'b0;
        act_req = 2'b11; col_req = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset holds the idle command even with requests present
        check(cmd_kind == 2'd0 && cmd_bank == '0 && cmd_addr == '0 && !cmd_auto_pre, "R1",
              int'({cmd_kind, cmd_bank, cmd_addr, cmd_auto_pre}), 0);
        @(negedge clk);
        clear_inputs();
        rst_n = 1'b1;
        @(negedge clk);

        // R8: two precharges, precharge-first; bank 0 must win
        policy = 2'd1; pre_req = 2'b11;
        #1;
        check(pre_ack == 2'b01, "R8", int'(pre_ack), 1);
        @(negedge clk);
        // R8: two activations, row-first; bank 0 must win
        pre_req = '0; policy = 2'd2; act_req = 2'b11;
        #1;
        check(act_ack == 2'b01, "R8", int'(act_ack), 1);
        @(negedge clk);

        // Near-exhaustive sweep of the two-bank configuration
        for (int pol = 0; pol < 4; pol++)
            for (int pr = 0; pr < 4; pr++)
                for (int ar = 0; ar < 4; ar++)
                    for (int cv = 0; cv < 8; cv++)
                        for (int p = 0; p < 4; p++) begin
                            policy       = 2'(pol);
                            pre_req      = 2'(pr);
                            act_req      = 2'(ar);
                            col_req      = cv[0];
                            col_bank     = cv[1];
                            col_auto_pre = cv[2];
                            for (int b = 0; b < NB; b++) begin
                                pre_age[b*AGE_W +: AGE_W] = 2'((p + b) % 4);
                                act_age[b*AGE_W +: AGE_W] = 2'((p * 3 + b + 1) % 4);
                                act_row[b*ROW_W +: ROW_W] = 4'((5 + b * 6 + p * 3) % 16);
                            end
                            col_age  = 2'((p + 2) % 4);
                            col_addr = 3'((p * 2 + 1 + cv) % 8);
                            run_vector(ptag[pol]);
                        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule